// File: doc/BRIEF.md
# Stipple and Blit Pixel Write Engine

This block modifies an 8-bit-per-pixel frame store on behalf of a host that issues 32-bit register writes. Each drawing command is a pair of writes. The first write of the pair has address bit 2 clear and holds a colour. The second write has address bit 2 set and starts the operation. Address bit 23 selects one of two windows: the stipple window or the blit window. The target pixel index comes from address bits 22:3.

A stipple writes the latched colour byte to the 32 pixels that follow the target. A 32-bit mask selects which of those pixels are written, taking the most significant bit first. A blit works on a run of 1 to 32 pixels. It either fills the run with the colour or copies the run from a source pixel index, one byte at a time in increasing address order. The engine reaches memory through a synchronous single-port byte memory interface. Read data returns one cycle after the read is issued.

The sequencer has five states:
- IDLE waits for writes. A stipple trigger moves it to STIPPLE. A blit trigger whose source is all ones moves it to FILL. Any other blit trigger moves it to COPY_RD.
- STIPPLE spends one cycle per mask bit and returns to IDLE after bit 0.
- FILL writes one pixel per cycle and returns to IDLE after the last pixel of the run.
- COPY_RD reads one source byte and always moves to COPY_WR.
- COPY_WR writes that byte to the destination. It then returns to COPY_RD, or to IDLE after the last pixel.

The write port stalls in every state other than IDLE.

Top module: `stipblit_engine`

## Requirements
- R1: When `wr_ready` is high, a write with `wr_addr[2]`=0 stores `wr_data[7:0]` as the pending colour. It causes no memory access and does not make the engine busy.
- R2: When `wr_ready` is high, a write with `wr_addr[2]`=1 starts an operation. The target pixel index is `wr_addr[22:3]` taken modulo 2^PIX_AW.
- R3: A trigger with `wr_addr[23]`=0 is a stipple. It takes exactly 32 busy cycles. Pixel target+k receives the colour byte when `wr_data[31-k]` is 1.
- R4: In a stipple, a pixel whose mask bit is 0 keeps its old value. A mask of all zeros changes no pixel.
- R5: A trigger with `wr_addr[23]`=1 is a blit. Its run length is `wr_data[28:24]`+1, which ranges from 1 to 32 pixels.
- R6: A blit whose `wr_data[23:0]` equals 24'hFFFFFF writes the colour byte to every pixel of the run. It takes one busy cycle per pixel.
- R7: A blit with any other `wr_data[23:0]` copies the run from source index `wr_data[23:0]` modulo 2^PIX_AW. It takes two busy cycles per pixel, a read followed by a write. Pixels are handled in increasing address order, so overlapping runs behave like a forward byte copy.
- R8: `wr_ready` is low and `busy` is high for as long as an operation runs. A write presented during that time waits and is accepted once the engine returns to IDLE.
- R9: A read request returns `rd_data`=0 with `rd_valid` high on the following cycle.
- R10: After reset the engine is idle, `wr_ready` is high, no memory access is issued and the pending colour is 0.
- R11: Target and source pixel addresses wrap modulo 2^PIX_AW within a run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write request |
| wr_addr | input | 22 | Byte address bits 23:2: window select, target index, trigger flag |
| wr_data | input | 32 | Write data: colour, mask, or blit source and length |
| wr_ready | output | 1 | Write accepted on an edge where both wr_en and wr_ready are high |
| rd_en | input | 1 | Register read request |
| rd_data | output | 32 | Read data, always zero |
| rd_valid | output | 1 | Read data valid, one cycle after rd_en |
| busy | output | 1 | Operation in progress |
| mem_en | output | 1 | Pixel memory access enable |
| mem_we | output | 1 | Pixel memory write enable |
| mem_addr | output | PIX_AW | Pixel memory byte address |
| mem_wdata | output | 8 | Pixel memory write byte |
| mem_rdata | input | 8 | Pixel memory read byte, valid one cycle after a read |

## Verification
The assertions assume two things about the memory. It is a true single-port store that returns read data exactly one cycle after a read. It never needs a wait state, so every COPY_RD can be followed at once by its COPY_WR. They also assume the host keeps `wr_en` and its payload stable while `wr_ready` is low. The bench ensures this by driving writes only at the falling edge and holding them until an accepting rising edge has passed. Its memory model answers every read on the next edge, and an array in the bench replays each command against the same seeded image.

// File: rtl/stipblit_pkg.sv
package stipblit_pkg;

    localparam int IDX_W     = 20;
    localparam int RUN_W     = 5;
    localparam int MASK_W    = 32;
    localparam int SRC_W     = 24;
    localparam logic [SRC_W-1:0] FILL_CODE = '1;

    typedef enum logic {
        OP_STIP = 1'b0,
        OP_BLIT = 1'b1
    } op_e;

    typedef struct packed {
        op_e               op;
        logic              trig;
        logic              fill;
        logic [IDX_W-1:0]  dst;
        logic [IDX_W-1:0]  src;
        logic [RUN_W-1:0]  len_m1;
        logic [MASK_W-1:0] mask;
        logic [7:0]        colour;
    } cmd_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_STIP,
        S_FILL,
        S_CP_RD,
        S_CP_WR
    } state_e;

endpackage

// File: rtl/stipblit_decode.sv
module stipblit_decode
    import stipblit_pkg::*;
(
    input  logic [23:2] wr_addr,
    input  logic [31:0] wr_data,
    output cmd_t        cmd
);

    always_comb begin
        cmd.op     = wr_addr[23] ? OP_BLIT : OP_STIP;
        cmd.trig   = wr_addr[2];
        cmd.dst    = wr_addr[22:3];
        cmd.src    = wr_data[IDX_W-1:0];
        cmd.fill   = (wr_data[SRC_W-1:0] == FILL_CODE);
        cmd.len_m1 = wr_data[SRC_W+RUN_W-1:SRC_W];
        cmd.mask   = wr_data;
        cmd.colour = wr_data[7:0];
    end

endmodule

// File: rtl/stipblit_seq.sv
module stipblit_seq
    import stipblit_pkg::*;
#(
    parameter int PIX_AW = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  cmd_t              cmd,
    output logic              wr_ready,
    output logic              busy,
    output logic              mem_en,
    output logic              mem_we,
    output logic [PIX_AW-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic [7:0]        mem_rdata
);

    localparam logic [RUN_W-1:0] STIP_LAST = RUN_W'(MASK_W - 1);

    state_e             st, st_nx;
    logic [7:0]         col_q;
    logic [PIX_AW-1:0]  dst_q, src_q;
    logic [RUN_W-1:0]   idx_q, last_q;
    logic [MASK_W-1:0]  mask_q;
    logic               accept, go, set_col, run_end;
    logic [PIX_AW-1:0]  dst_at, src_at;

    assign wr_ready = (st == S_IDLE);
    assign busy     = !wr_ready;
    assign accept   = wr_en && wr_ready;
    assign go       = accept && cmd.trig;
    assign set_col  = accept && !cmd.trig;
    assign run_end  = (idx_q == last_q);
    assign dst_at   = dst_q + PIX_AW'(idx_q);
    assign src_at   = src_q + PIX_AW'(idx_q);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= st_nx;
    end

    // next state
    always_comb begin
        st_nx = st;
        unique case (st)
            S_IDLE: begin
                if (go) begin
                    if (cmd.op == OP_STIP) st_nx = S_STIP;
                    else if (cmd.fill)     st_nx = S_FILL;
                    else                   st_nx = S_CP_RD;
                end
            end
            S_STIP:  if (idx_q == STIP_LAST) st_nx = S_IDLE;
            S_FILL:  if (run_end) st_nx = S_IDLE;
            S_CP_RD: st_nx = S_CP_WR;
            S_CP_WR: st_nx = run_end ? S_IDLE : S_CP_RD;
            default: st_nx = S_IDLE;
        endcase
    end

    // memory-side outputs
    always_comb begin
        mem_en    = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = dst_at;
        mem_wdata = col_q;
        unique case (st)
            S_IDLE: ;
            S_STIP: begin
                mem_en = mask_q[MASK_W-1];
                mem_we = mask_q[MASK_W-1];
            end
            S_FILL: begin
                mem_en = 1'b1;
                mem_we = 1'b1;
            end
            S_CP_RD: begin
                mem_en   = 1'b1;
                mem_addr = src_at;
            end
            S_CP_WR: begin
                mem_en    = 1'b1;
                mem_we    = 1'b1;
                mem_wdata = mem_rdata;
            end
            default: ;
        endcase
    end

    // operand registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col_q  <= '0;
            dst_q  <= '0;
            src_q  <= '0;
            idx_q  <= '0;
            last_q <= '0;
            mask_q <= '0;
        end else begin
            if (set_col) col_q <= cmd.colour;
            if (go) begin
                dst_q  <= cmd.dst[PIX_AW-1:0];
                src_q  <= cmd.src[PIX_AW-1:0];
                last_q <= cmd.len_m1;
                mask_q <= cmd.mask;
                idx_q  <= '0;
            end
            unique case (st)
                S_STIP: begin
                    mask_q <= mask_q << 1;
                    idx_q  <= idx_q + 1'b1;
                end
                S_FILL, S_CP_WR: idx_q <= idx_q + 1'b1;
                default: ;
            endcase
        end
    end

    // R11: inside a fill run the address advances by one per cycle
    p_run_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_FILL && $past(st) == S_FILL) |-> mem_addr == $past(mem_addr) + 1'b1);

    // R7: a copy write lands on the address following the previous write
    p_copy_order_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_CP_RD && $past(st) == S_CP_WR) |=> mem_addr == $past(mem_addr, 2) + 1'b1);

endmodule

// File: rtl/stipblit_engine.sv
module stipblit_engine
    import stipblit_pkg::*;
#(
    parameter int PIX_AW = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [23:2]       wr_addr,
    input  logic [31:0]       wr_data,
    output logic              wr_ready,
    input  logic              rd_en,
    output logic [31:0]       rd_data,
    output logic              rd_valid,
    output logic              busy,
    output logic              mem_en,
    output logic              mem_we,
    output logic [PIX_AW-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic [7:0]        mem_rdata
);

    cmd_t cmd;

    stipblit_decode u_dec (
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .cmd     (cmd)
    );

    stipblit_seq #(.PIX_AW(PIX_AW)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .cmd       (cmd),
        .wr_ready  (wr_ready),
        .busy      (busy),
        .mem_en    (mem_en),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) rd_valid <= 1'b0;
        else        rd_valid <= rd_en;
    end
    assign rd_data = '0;

    // R1: no memory traffic while idle
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_en);

    // R1: a colour write leaves the engine idle
    p_colour_only_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_ready && !wr_addr[2]) |=> !busy);

    // R8: an accepted trigger makes the engine busy on the next cycle
    p_start_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_ready && wr_addr[2]) |=> busy && !wr_ready);

    // R7: every source read is followed directly by a write
    p_read_then_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && !mem_we) |=> (mem_en && mem_we));

endmodule

// File: tb/stipblit_engine_tb.sv
module stipblit_engine_tb;

    localparam int AW    = 12;
    localparam int DEPTH = 1 << AW;

    typedef struct packed {
        logic        blit;
        logic [31:0] colour;
        logic [19:0] tgt;
        logic [31:0] data;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 32'h0000_00A5, 20'h00010, 32'h8000_0001},  // R3 end bits
        '{1'b0, 32'h0000_003C, 20'h00100, 32'hF0F0_5A5A},  // R3 pattern
        '{1'b0, 32'h0000_00FF, 20'h00200, 32'h0000_0000},  // R4 empty mask
        '{1'b1, 32'h0000_0077, 20'h00300, 32'h1FFF_FFFF},  // R6 fill 32
        '{1'b1, 32'h0000_0011, 20'h00320, 32'h00FF_FFFF},  // R5 fill 1
        '{1'b1, 32'h0000_0000, 20'h00400, 32'h0F00_0040},  // R7 copy 16
        '{1'b1, 32'h0000_0000, 20'h00401, 32'h0700_0400},  // R7 overlap fwd
        '{1'b1, 32'h0000_0000, 20'h00500, 32'h0300_0FFF},  // R11 src wrap, not fill
        '{1'b0, 32'h0000_00C3, 20'h12FF0, 32'hFFFF_FFFF},  // R2 R11 tgt wrap
        '{1'b1, 32'hABCD_EF12, 20'h007FE, 32'h03FF_FFFF},  // R6 low byte only
        '{1'b1, 32'h0000_0000, 20'h00400, 32'h0500_0402}   // R7 overlap back
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [23:2]       wr_addr = '0;
    logic [31:0]       wr_data = '0;
    logic              wr_ready, rd_en = 1'b0, rd_valid, busy;
    logic [31:0]       rd_data;
    logic              mem_en, mem_we;
    logic [AW-1:0]     mem_addr;
    logic [7:0]        mem_wdata, mem_rdata;

    logic [7:0] pmem  [DEPTH];
    logic [7:0] ref_m [DEPTH];
    int checks = 0, fails = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    stipblit_engine #(.PIX_AW(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_ready(wr_ready), .rd_en(rd_en),
        .rd_data(rd_data), .rd_valid(rd_valid), .busy(busy),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    function automatic logic [7:0] seed(int i);
        return 8'((i * 7 + 3) ^ (i >> 8));
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) pmem[i] <= seed(i);
            mem_rdata <= '0;
        end else if (mem_en) begin
            if (mem_we) pmem[mem_addr] <= mem_wdata;
            else        mem_rdata <= pmem[mem_addr];
        end
    end

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic host_wr(logic [23:2] a, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        while (!wr_ready) @(negedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        while (busy) begin n++; @(negedge clk); end
    endtask

    task automatic ref_apply(vec_t v);
        logic [AW-1:0] t, s;
        int len;
        t = v.tgt[AW-1:0];
        if (!v.blit) begin
            for (int k = 0; k < 32; k++)
                if (v.data[31-k]) ref_m[AW'(t + AW'(k))] = v.colour[7:0];
        end else begin
            len = int'(v.data[28:24]) + 1;
            s = v.data[AW-1:0];
            for (int k = 0; k < len; k++) begin
                if (v.data[23:0] == 24'hFFFFFF) ref_m[AW'(t + AW'(k))] = v.colour[7:0];
                else ref_m[AW'(t + AW'(k))] = ref_m[AW'(s + AW'(k))];
            end
        end
    endtask

    function automatic int exp_cycles(vec_t v);
        if (!v.blit) return 32;
        if (v.data[23:0] == 24'hFFFFFF) return int'(v.data[28:24]) + 1;
        return 2 * (int'(v.data[28:24]) + 1);
    endfunction

    task automatic cmp_mem(string req);
        int bad = 0, first = -1;
        for (int i = 0; i < DEPTH; i++)
            if (pmem[i] !== ref_m[i]) begin
                bad++;
                if (first < 0) first = i;
            end
        if (first < 0) check(1'b1, req, 0, 0);
        else check(1'b0, {req, " mem"}, int'(pmem[first]), int'(ref_m[first]));
    endtask

    task automatic run_vec(vec_t v, string req);
        int n;
        host_wr({v.blit, 20'h0, 1'b0}, v.colour);
        host_wr({v.blit, v.tgt, 1'b1}, v.data);
        wait_idle(n);
        check(n == exp_cycles(v), {req, " cycles"}, n, exp_cycles(v));
        ref_apply(v);
        cmp_mem(req);
    endtask

    initial begin
        #400000;
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        int n;
        vec_t dv;
        for (int i = 0; i < DEPTH; i++) ref_m[i] = seed(i);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        check(wr_ready && !busy && !mem_en, "R10", {wr_ready, busy, mem_en}, 3'b100);
        // R10 pending colour is 0: trigger a fill without setting a colour
        host_wr({1'b1, 20'h00700, 1'b1}, 32'h00FF_FFFF);
        wait_idle(n);
        dv = '{1'b1, 32'h0, 20'h00700, 32'h00FF_FFFF};
        ref_apply(dv);
        cmp_mem("R10 colour");

        for (int i = 0; i < NV; i++) run_vec(VEC[i], $sformatf("R3/R5/R6/R7 vec%0d", i));

        // R9 reads return zero
        @(negedge clk); rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0;
        check(rd_valid && rd_data == 0, "R9", rd_data, 0);

        // R1 colour-only write: no access, not busy
        host_wr({1'b0, 20'h00900, 1'b0}, 32'h0000_005E);
        n = 0;
        repeat (4) begin
            if (mem_en || busy) n++;
            @(negedge clk);
        end
        check(n == 0, "R1", n, 0);
        cmp_mem("R1 mem");

        // R8 hold-off: colour write presented while a stipple runs
        host_wr({1'b0, 20'h0, 1'b1}, 32'h0F00_0000);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = {1'b0, 20'h0, 1'b0}; wr_data = 32'h0000_0099;
        check(!wr_ready && busy, "R8 ready", wr_ready, 0);
        while (!wr_ready) @(negedge clk);
        @(negedge clk); wr_en = 1'b0;
        dv = '{1'b0, 32'h5E, 20'h0, 32'h0F00_0000};
        ref_apply(dv);
        cmp_mem("R8 running op");
        host_wr({1'b1, 20'h00610, 1'b1}, 32'h00FF_FFFF);
        wait_idle(n);
        dv = '{1'b1, 32'h99, 20'h00610, 32'h00FF_FFFF};
        ref_apply(dv);
        cmp_mem("R8 held write");

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule